// File: doc/BRIEF.md
# Fractional Clock Divider with Committed Updates

This block turns an input clock-enable stream into a slower stream of single-cycle output pulses. The division ratio is an unsigned fixed-point number: a divisor register field carries integer bits on top and fraction bits at the bottom, and the value held in the field is the divisor minus one, where that one counts at the lowest integer bit rather than at the lowest fraction bit. A field value of zero therefore divides by exactly one. Internally the divisor is handled as a scaled integer (divisor shifted left by the fraction width), so an accumulator that gains one scaled unit per enabled input cycle and gives back one scaled divisor per pulse produces the fractional rate with no extra fraction logic.

Software programs a new ratio by writing the field and setting a trigger bit in the same 32-bit control word. The new value stays staged and inactive until the block swaps it in at the next output pulse; the trigger bit reads 1 while the swap is outstanding and drops to 0 in the very cycle the pulse appears, so software can poll it. The swap can only happen while the upstream gate enables the clock; while the gate is shut the request simply waits. Any write that arrives while a request is outstanding is discarded.

Top module: `fdiv_frac_divider`

## Requirements
- R1: After reset the staged and active fields are 0 (divide by one), the trigger reads 0, the readback word is all zero and no pulse is produced.
- R2: The divisor field occupies bits [FIELD_SHIFT+FIELD_W-1:FIELD_SHIFT] of the control word (default bits 15:8) and the trigger is bit TRIG_BIT (default bit 0); a read returns the staged field and the trigger state in those positions and 0 in every other bit.
- R3: With the low FRAC_W bits (default 3) of field value F taken as fraction, the divisor is (F + 2^FRAC_W) / 2^FRAC_W; over M enabled input cycles counted from a commit, exactly floor(M * 2^FRAC_W / (F + 2^FRAC_W)) pulses appear.
- R4: A field write with the trigger bit at 0 updates only the staged value and leaves the output rate unchanged.
- R5: A write with the trigger bit at 1 makes the trigger read 1 from the next cycle; the staged value becomes active at the next output pulse, the trigger reads 0 in the same cycle that pulse is high, and the new ratio starts from a zero accumulator.
- R6: While the gate input is low no pulse is produced, the accumulator holds its value and an outstanding trigger stays at 1.
- R7: While the trigger reads 1, writes change neither the staged field nor the trigger.
- R8: A pulse is high only in the cycle following an input cycle in which the gate was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word readback |
| gate_en | input | 1 | Clock enable from the upstream gate |
| div_pulse | output | 1 | Divided enable pulse, one cycle wide |

## Verification
The rate is measured by counting pulses over a fixed window of 40 enabled cycles right after each commit, for field values that give divide by one, by two, by 1.5, by 1.375, by 2.5 and the largest divisor; integer ratios show the minus-one offset, the fractional ones show that the offset lands above the fraction bits, and the largest one shows that the accumulator does not overflow. Each commit is polled through the trigger bit and the pulse state at the clearing sample separates a swap at a pulse boundary from an immediate one. A write without trigger, a trigger issued with the gate shut, and writes during an outstanding request separate staging from activation and show that discarded writes leave the readback untouched.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  // Divisor in scaled units: stored field plus one integer step.
  function automatic logic [31:0] scaled_divisor(input logic [31:0] field, input int frac_w);
    return field + (32'd1 << frac_w);
  endfunction

  // Accumulator step for one enabled input cycle.
  function automatic logic [31:0] unit_step(input int frac_w);
    return 32'd1 << frac_w;
  endfunction

endpackage

// File: rtl/fdiv_regs.sv
module fdiv_regs #(
  parameter int FIELD_W     = 8,
  parameter int FIELD_SHIFT = 8,
  parameter int TRIG_BIT    = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  input  logic               commit,
  output logic [FIELD_W-1:0] staged_field,
  output logic [FIELD_W-1:0] active_field,
  output logic               trig_pending,
  output logic [31:0]        rd_data
);

  logic wr_accept;
  logic unused_wr;

  assign wr_accept = wr_en && !trig_pending;
  assign unused_wr = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged_field <= '0;
      trig_pending <= 1'b0;
    end else if (wr_accept) begin
      staged_field <= wr_data[FIELD_SHIFT +: FIELD_W];
      trig_pending <= wr_data[TRIG_BIT];
    end else if (commit) begin
      trig_pending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_field <= '0;
    end else if (commit) begin
      active_field <= staged_field;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[FIELD_SHIFT +: FIELD_W] = staged_field;
    rd_data[TRIG_BIT] = trig_pending;
  end

endmodule

// File: rtl/fdiv_accum.sv
module fdiv_accum #(
  parameter int FIELD_W = 8,
  parameter int FRAC_W  = 3,
  localparam int ACC_W  = FIELD_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_en,
  input  logic             restart,
  input  logic [ACC_W-1:0] scaled,
  output logic [ACC_W-1:0] phase_acc,
  output logic             hit,
  output logic             pulse
);

  localparam logic [31:0] STEP32 = fdiv_pkg::unit_step(FRAC_W);
  localparam logic [ACC_W-1:0] STEP = STEP32[ACC_W-1:0];

  logic [ACC_W-1:0] sum;

  assign sum = phase_acc + STEP;
  assign hit = gate_en && (sum >= scaled);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_acc <= '0;
      pulse     <= 1'b0;
    end else begin
      pulse <= hit;
      if (gate_en) begin
        if (restart) begin
          phase_acc <= '0;
        end else if (hit) begin
          phase_acc <= sum - scaled;
        end else begin
          phase_acc <= sum;
        end
      end
    end
  end

endmodule

// File: rtl/fdiv_frac_divider.sv
module fdiv_frac_divider #(
  parameter int FIELD_W     = 8,
  parameter int FRAC_W      = 3,
  parameter int FIELD_SHIFT = 8,
  parameter int TRIG_BIT    = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        gate_en,
  output logic        div_pulse
);

  localparam int ACC_W = FIELD_W + 2;

  logic [FIELD_W-1:0] staged_field;
  logic [FIELD_W-1:0] active_field;
  logic               trig_pending;
  logic [ACC_W-1:0]   phase_acc;
  logic [ACC_W-1:0]   scaled_div_w;
  logic [31:0]        scaled32;
  logic               hit_evt;
  logic               commit_evt;

  assign scaled32     = fdiv_pkg::scaled_divisor(32'(active_field), FRAC_W);
  assign scaled_div_w = scaled32[ACC_W-1:0];
  assign commit_evt   = hit_evt && trig_pending;

  fdiv_regs #(
    .FIELD_W(FIELD_W), .FIELD_SHIFT(FIELD_SHIFT), .TRIG_BIT(TRIG_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .commit(commit_evt), .staged_field(staged_field),
    .active_field(active_field), .trig_pending(trig_pending),
    .rd_data(rd_data)
  );

  fdiv_accum #(
    .FIELD_W(FIELD_W), .FRAC_W(FRAC_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .restart(commit_evt),
    .scaled(scaled_div_w), .phase_acc(phase_acc), .hit(hit_evt),
    .pulse(div_pulse)
  );

endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker #(
  parameter int FIELD_W = 8,
  localparam int ACC_W  = FIELD_W + 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               gate_en,
  input logic               div_pulse,
  input logic               trig_pending,
  input logic [FIELD_W-1:0] staged_field,
  input logic [FIELD_W-1:0] active_field,
  input logic [ACC_W-1:0]   phase_acc,
  input logic [ACC_W-1:0]   scaled_div_w
);

  // R3
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_acc < scaled_div_w);

  // R4
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_pending |=> $stable(active_field));

  // R5
  trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_pending) |-> div_pulse);

  // R6
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> ($stable(phase_acc) && !div_pulse));

  // R7
  pend_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pending && wr_en) |=> ($stable(staged_field) && trig_pending));

  // R8
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> $past(gate_en));

endmodule

bind fdiv_frac_divider fdiv_checker #(.FIELD_W(FIELD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .gate_en(gate_en),
  .div_pulse(div_pulse), .trig_pending(trig_pending),
  .staged_field(staged_field), .active_field(active_field),
  .phase_acc(phase_acc), .scaled_div_w(scaled_div_w)
);

// File: tb/test_fdiv_frac_divider.sv
module test_fdiv_frac_divider;

  localparam int CLK_PERIOD = 10;
  localparam int SHIFT = 8;
  localparam int WIN = 40;
  localparam int NVEC = 6;
  // field value, expected pulses in WIN cycles = floor(8*WIN/(F+8))
  localparam int VEC_F   [NVEC] = '{0, 8, 4, 3, 255, 12};
  localparam int VEC_EXP [NVEC] = '{40, 20, 26, 29, 1, 16};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic gate_en = 1'b0;
  logic div_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdiv_frac_divider i_fdiv_frac_divider (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .gate_en(gate_en), .div_pulse(div_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_word(input int data);
    wr_en = 1'b1;
    wr_data = 32'(data);
    step();
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      step();
      cnt += int'(div_pulse);
    end
  endtask

  task automatic wait_trig_clear(output int pulse_seen);
    pulse_seen = -1;
    for (int k = 0; k < 400; k++) begin
      step();
      if (!rd_data[0]) begin
        pulse_seen = int'(div_pulse);
        break;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int cnt;
    int pz;
    int held;
    @(negedge clk);
    repeat (3) step();
    // R1 reset state
    check("R1 readback after reset", int'(rd_data), 0);
    check("R1 pulse after reset", int'(div_pulse), 0);
    rst_n = 1'b1;
    gate_en = 1'b1;
    count_pulses(10, cnt);
    check("R1 divide by one after reset", cnt, 10);

    // R4 staging without trigger
    write_word(8 << SHIFT);
    check("R2 staged field readback, trigger 0", int'(rd_data), 8 << SHIFT);
    count_pulses(10, cnt);
    check("R4 rate unchanged without trigger", cnt, 10);

    // R3 / R5 table of ratios
    for (int i = 0; i < NVEC; i++) begin
      write_word((VEC_F[i] << SHIFT) | 1);
      check("R5 trigger reads 1 after write", int'(rd_data[0]), 1);
      wait_trig_clear(pz);
      check("R5 trigger clears with pulse high", pz, 1);
      count_pulses(WIN, cnt);
      check($sformatf("R3 pulses for field %0d", VEC_F[i]), cnt, VEC_EXP[i]);
      check("R2 field readback after commit", int'(rd_data),
            VEC_F[i] << SHIFT);
    end

    // R6 gate closed: request waits, no pulses
    gate_en = 1'b0;
    step();
    step();
    write_word((20 << SHIFT) | 1);
    cnt = 0;
    held = 1;
    for (int k = 0; k < 20; k++) begin
      step();
      cnt += int'(div_pulse);
      if (!rd_data[0]) held = 0;
    end
    check("R6 no pulses while gate low", cnt, 0);
    check("R6 trigger held while gate low", held, 1);

    // R7 writes while pending are discarded
    write_word(40 << SHIFT);
    check("R7 field write ignored while pending", int'(rd_data),
          (20 << SHIFT) | 1);
    write_word((40 << SHIFT) | 1);
    check("R7 triggered write ignored while pending", int'(rd_data),
          (20 << SHIFT) | 1);

    // reopen gate: commit of field 20 (scaled 28)
    gate_en = 1'b1;
    wait_trig_clear(pz);
    check("R5 commit after gate reopens, pulse high", pz, 1);
    count_pulses(WIN, cnt);
    check("R3 pulses for field 20", cnt, 11);
    check("R2 readback holds field 20", int'(rd_data), 20 << SHIFT);

    finish_run();
  end

endmodule